// File: doc/BRIEF.md
# Two-Output Interrupt Controller with Register Access

This block gathers up to 95 level-sensitive interrupt sources into 32-bit register words. Source `n` is held in word `n/32`, at bit `n%32`. Each source has a pending latch, an enable bit, a mask bit and a routing select bit. The select bit steers the source to one of two processor lines: the normal interrupt output `irq_o` or the fast interrupt output `fiq_o`. A source that is high at a clock edge latches a pending bit. The bit goes into the IRQ pending bank when its select bit is 0 and into the FIQ pending bank when its select bit is 1. Software clears pending bits by writing ones.

Software reaches the block over a plain 32-bit register port that covers a 1 KiB window. A write takes effect at the rising clock edge on which `bus_sel` and `bus_we` are both high. A read is combinational: while `bus_sel` is high and `bus_we` is low, `bus_rdata` shows the addressed word. At all other times `bus_rdata` is 0. Four control words (vector, base address, protect, NMI control) are stored alongside the per-source words. The two outputs are plain OR reductions of the qualified pending state, so each line drops as soon as nothing qualifying remains.

The word index inside each bank comes from `bus_addr[3:2]`. The bank group comes from `bus_addr[9:4]`. Address bits [1:0] are not decoded.

Top module: `irqfiq_ctrl`

## Requirements
- R1: After reset every control, pending, select, enable and mask word reads 0, and `irq_o` and `fiq_o` are low.
- R2: Register groups are selected by `bus_addr[9:4]`: 0 for control, 1 for IRQ pending, 2 for FIQ pending, 3 for select, 4 for enable, 5 for mask. Within a group, `bus_addr[3:2]` selects the word (0 to 2). Within a bank word, source `n` sits at word `n/32`, bit `n%32`. A written select, enable or mask word reads back unchanged.
- R3: Control words are vector (index 0), base (index 1), protect (index 2) and NMI control (index 3). Writes to vector and base store the data with bits [1:0] forced to 0. Protect and NMI control store all 32 bits.
- R4: A write to an IRQ or FIQ pending word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A source that is high at a clock edge sets its IRQ pending bit if its select bit is 0, or its FIQ pending bit if its select bit is 1. The result is readable one cycle later.
- R6: If a source is high in the same cycle as a write-one-to-clear of its pending bit, the bit stays set. A held source therefore keeps its pending bit set.
- R7: `irq_o` is the OR, over all sources, of (IRQ pending & enable & ~mask & ~select). `fiq_o` is the same OR with FIQ pending and select. Both outputs follow register state without extra delay and drop when no qualifying source remains.
- R8: A source with mask bit 1, or with enable bit 0, does not affect either output, even though its pending bit stays readable.
- R9: IRQ and FIQ are evaluated independently, so both outputs can be high at once.
- R10: Reads of unmapped offsets (word index 3 of a bank group, and groups 6 and above) return 0. Writes to those offsets change nothing.
- R11: Bit 31 of word 2 (the position of a nonexistent source 95) reads as 0 in every bank and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 95 | Level interrupt sources |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupt pending, select, enable or mask bit shows at the ports in one of two ways. It is visible on the next combinational read of its word. If the source is unmasked and enabled, it is also visible on `irq_o` or `fiq_o` in the cycle right after the faulty edge. A source sent to the wrong bank shows up as the wrong output line rising and as the pending bit appearing in the other pending group. A broken clear shows up as an output that stays high after software has cleared every qualifying bit.

// File: rtl/irqfiq_pkg.sv
package irqfiq_pkg;
  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_CTL,
    FLD_IPEND,
    FLD_FPEND,
    FLD_SEL,
    FLD_EN,
    FLD_MASK
  } fld_e;
endpackage

// File: rtl/irqfiq_decode.sv
module irqfiq_decode
  import irqfiq_pkg::*;
#(
  parameter int AW        = 10,
  parameter int NUM_WORDS = 3
) (
  input  logic [AW-1:0] addr,
  output fld_e          fld,
  output logic [1:0]    idx,
  output logic          hit
);
  localparam int GW = AW - 4;

  logic [GW-1:0] grp;
  assign grp = addr[AW-1:4];
  assign idx = addr[3:2];

  always_comb begin
    case (grp)
      GW'(0):  fld = FLD_CTL;
      GW'(1):  fld = FLD_IPEND;
      GW'(2):  fld = FLD_FPEND;
      GW'(3):  fld = FLD_SEL;
      GW'(4):  fld = FLD_EN;
      GW'(5):  fld = FLD_MASK;
      default: fld = FLD_NONE;
    endcase
    if (fld != FLD_CTL && fld != FLD_NONE && int'(idx) >= NUM_WORDS)
      fld = FLD_NONE;
  end

  assign hit = (fld != FLD_NONE);
endmodule

// File: rtl/irqfiq_ctlregs.sv
module irqfiq_ctlregs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] vec_q, base_q, prot_q, nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (wr) begin
      case (idx)
        2'd0:    vec_q  <= {wdata[DW-1:2], 2'b00};
        2'd1:    base_q <= {wdata[DW-1:2], 2'b00};
        2'd2:    prot_q <= wdata;
        default: nmi_q  <= wdata;
      endcase
    end
  end

  always_comb begin
    case (idx)
      2'd0:    rdata = vec_q;
      2'd1:    rdata = base_q;
      2'd2:    rdata = prot_q;
      default: rdata = nmi_q;
    endcase
  end

  p_vec_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 2'd0) |=> (vec_q == {$past(wdata[DW-1:2]), 2'b00}));
  p_base_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 2'd1) |=> (base_q[1:0] == 2'b00));
endmodule

// File: rtl/irqfiq_bank.sv
module irqfiq_bank
  import irqfiq_pkg::*;
#(
  parameter int            DW    = 32,
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,
  input  logic          wr,
  input  fld_e          fld,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_hit,
  output logic          fiq_hit
);
  logic [DW-1:0] ipend_q, fpend_q, sel_q, en_q, mask_q;
  logic [DW-1:0] set_irq, set_fiq, clr_irq, clr_fiq;

  assign set_irq = src & ~sel_q & VALID;
  assign set_fiq = src & sel_q & VALID;
  assign clr_irq = (wr && fld == FLD_IPEND) ? wdata : '0;
  assign clr_fiq = (wr && fld == FLD_FPEND) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipend_q <= '0;
      fpend_q <= '0;
      sel_q   <= '0;
      en_q    <= '0;
      mask_q  <= '0;
    end else begin
      ipend_q <= (ipend_q & ~clr_irq) | set_irq;
      fpend_q <= (fpend_q & ~clr_fiq) | set_fiq;
      if (wr && fld == FLD_SEL)  sel_q  <= wdata & VALID;
      if (wr && fld == FLD_EN)   en_q   <= wdata & VALID;
      if (wr && fld == FLD_MASK) mask_q <= wdata & VALID;
    end
  end

  always_comb begin
    case (fld)
      FLD_IPEND: rdata = ipend_q;
      FLD_FPEND: rdata = fpend_q;
      FLD_SEL:   rdata = sel_q;
      FLD_EN:    rdata = en_q;
      FLD_MASK:  rdata = mask_q;
      default:   rdata = '0;
    endcase
  end

  assign irq_hit = |(ipend_q & en_q & ~mask_q & ~sel_q);
  assign fiq_hit = |(fpend_q & en_q & ~mask_q & sel_q);

  p_irq_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src & ~sel_q & VALID)) |=>
      ((ipend_q & $past(src & ~sel_q & VALID)) == $past(src & ~sel_q & VALID)));
  p_fiq_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src & sel_q & VALID)) |=>
      ((fpend_q & $past(src & sel_q & VALID)) == $past(src & sel_q & VALID)));
  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && fld == FLD_IPEND) |=> ((ipend_q & $past(wdata & ~src)) == '0));
  p_w1c_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && fld == FLD_IPEND) |=>
      ((ipend_q & $past(ipend_q & ~wdata)) == $past(ipend_q & ~wdata)));
endmodule

// File: rtl/irqfiq_ctrl.sv
module irqfiq_ctrl
  import irqfiq_pkg::*;
#(
  parameter int NUM_SRC = 95,
  parameter int AW      = 10,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NUM_WORDS = (NUM_SRC + DW - 1) / DW;
  localparam int PAD_W     = NUM_WORDS * DW;

  fld_e       fld;
  logic [1:0] idx;
  logic       dec_hit;
  logic       wr;
  logic [DW-1:0] ctl_rd;
  logic [PAD_W-1:0] src_pad;
  logic [DW-1:0] bank_rd  [NUM_WORDS];
  logic [NUM_WORDS-1:0] bank_irq, bank_fiq;
  logic [DW-1:0] bank_rd_or;

  assign wr      = bus_sel & bus_we & dec_hit;
  assign src_pad = PAD_W'(src_i);

  irqfiq_decode #(.AW(AW), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr(bus_addr), .fld(fld), .idx(idx), .hit(dec_hit)
  );

  irqfiq_ctlregs #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(wr && fld == FLD_CTL), .idx(idx),
    .wdata(bus_wdata), .rdata(ctl_rd)
  );

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_bank
    localparam logic [DW-1:0] VMASK = ((g + 1) * DW <= NUM_SRC) ? {DW{1'b1}} :
                                      DW'((64'd1 << (NUM_SRC - g * DW)) - 64'd1);
    logic [DW-1:0] rd_raw;
    irqfiq_bank #(.DW(DW), .VALID(VMASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .src(src_pad[g*DW +: DW]),
      .wr(wr && int'(idx) == g), .fld(fld), .wdata(bus_wdata),
      .rdata(rd_raw), .irq_hit(bank_irq[g]), .fiq_hit(bank_fiq[g])
    );
    assign bank_rd[g] = (int'(idx) == g) ? rd_raw : '0;
  end

  always_comb begin
    bank_rd_or = '0;
    for (int i = 0; i < NUM_WORDS; i++) bank_rd_or |= bank_rd[i];
  end

  always_comb begin
    if (!bus_sel || bus_we || !dec_hit) bus_rdata = '0;
    else if (fld == FLD_CTL)            bus_rdata = ctl_rd;
    else                                bus_rdata = bank_rd_or;
  end

  assign irq_o = |bank_irq;
  assign fiq_o = |bank_fiq;

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !dec_hit) |-> (bus_rdata == '0));
  p_no_read_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |-> (bus_rdata == '0));
endmodule

// File: tb/irqfiq_ctrl_bench.sv
module irqfiq_ctrl_bench;
  localparam int NS = 95;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irqfiq_ctrl u_irqfiq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic [9:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{10'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 8'd3},  // R3 vector low bits cleared
    '{10'h004, 32'h1234_5677, 32'h1234_5674, 8'd3},  // R3 base low bits cleared
    '{10'h008, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 8'd3},  // R3 protect full width
    '{10'h00C, 32'h0000_003F, 32'h0000_003F, 8'd3},  // R3 NMI control
    '{10'h030, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 8'd2},  // R2 select word 0
    '{10'h034, 32'h1234_ABCD, 32'h1234_ABCD, 8'd2},  // R2 select word 1
    '{10'h038, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 8'd11}, // R11 select word 2 top bit
    '{10'h040, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd2},  // R2 enable word 0
    '{10'h048, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 8'd11}, // R11 enable word 2 top bit
    '{10'h058, 32'h8000_0001, 32'h0000_0001, 8'd11}, // R11 mask word 2 top bit
    '{10'h054, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd2},  // R2 mask word 1
    '{10'h03C, 32'h0000_FFFF, 32'h0000_0000, 8'd10}, // R10 word index 3
    '{10'h060, 32'h0000_FFFF, 32'h0000_0000, 8'd10}, // R10 group 6
    '{10'h3FC, 32'hFFFF_FFFF, 32'h0000_0000, 8'd10}  // R10 window top
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src_i[n] = 1'b1;
    @(negedge clk); src_i[n] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // Table walk: write then read back (R2, R3, R10, R11)
    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].addr, TBL[i].wd);
      rd(TBL[i].addr, r);
      check(r, TBL[i].exp, $sformatf("R%0d table entry %0d", TBL[i].req, i));
    end
    // R10: unmapped writes left the mapped words intact
    rd(10'h030, r); check(r, 32'h0F0F_0F0F, "R10 select word 0 intact");

    // R1: reset clears everything
    do_reset();
    #1;
    check({30'd0, irq_o, fiq_o}, 32'd0, "R1 outputs low");
    for (int a = 0; a < 24; a++) begin
      if ((a % 4) != 3 || a < 4) begin
        rd(10'(a * 4), r);
        check(r, 32'd0, $sformatf("R1 word at %h", a * 4));
      end
    end

    // R5/R7: IRQ path through source 3
    wr(10'h040, 32'hFFFF_FFFF);
    pulse(3);
    rd(10'h010, r); check(r, 32'h0000_0008, "R5 irq pending bit 3");
    rd(10'h020, r); check(r, 32'h0, "R5 fiq pending empty");
    check({31'd0, irq_o}, 32'd1, "R7 irq high");
    check({31'd0, fiq_o}, 32'd0, "R7 fiq low");

    // R8: mask hides, unmask restores
    wr(10'h050, 32'h0000_0008);
    #1 check({31'd0, irq_o}, 32'd0, "R8 masked irq low");
    rd(10'h010, r); check(r, 32'h0000_0008, "R8 pending kept under mask");
    wr(10'h050, 32'h0);
    #1 check({31'd0, irq_o}, 32'd1, "R8 unmasked irq high");

    // R4: partial write-one-to-clear
    pulse(5);
    wr(10'h010, 32'h0000_0008);
    rd(10'h010, r); check(r, 32'h0000_0020, "R4 only bit 3 cleared");
    check({31'd0, irq_o}, 32'd1, "R7 irq still high from source 5");

    // R5/R9: source 36 routed to FIQ (word 1 bit 4)
    wr(10'h034, 32'h0000_0010);
    wr(10'h044, 32'h0000_0010);
    pulse(36);
    rd(10'h024, r); check(r, 32'h0000_0010, "R5 fiq pending word 1 bit 4");
    rd(10'h014, r); check(r, 32'h0, "R5 irq pending word 1 empty");
    check({30'd0, irq_o, fiq_o}, 32'd3, "R9 both outputs high");

    // R8: enable cleared for FIQ source
    wr(10'h044, 32'h0);
    #1 check({31'd0, fiq_o}, 32'd0, "R8 disabled fiq low");
    rd(10'h024, r); check(r, 32'h0000_0010, "R8 fiq pending kept");
    wr(10'h024, 32'h0000_0010);
    rd(10'h024, r); check(r, 32'h0, "R4 fiq pending cleared");

    // R6: held source wins over clear
    @(negedge clk); src_i[5] = 1'b1;
    wr(10'h010, 32'h0000_0020);
    rd(10'h010, r); check(r, 32'h0000_0020, "R6 set wins over clear");
    @(negedge clk); src_i[5] = 1'b0;
    wr(10'h010, 32'h0000_0020);
    rd(10'h010, r); check(r, 32'h0, "R6 cleared after release");
    #1 check({30'd0, irq_o, fiq_o}, 32'd0, "R7 outputs drop when nothing qualifies");

    // R11: top bit of word 2 never latches
    wr(10'h048, 32'hFFFF_FFFF);
    @(negedge clk); src_i[94] = 1'b1;
    @(negedge clk); src_i[94] = 1'b0;
    rd(10'h018, r); check(r, 32'h4000_0000, "R11 source 94 at word 2 bit 30 only");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule